// File: doc/BRIEF.md
# Adaptive Delta Stream Decoder

This block turns a one-bit adaptive delta stream back into signed multi-bit samples. Each accepted bit moves a running estimate up or down by a step size. The step size adapts to the recent bit history. A run of equal bits means the signal is climbing or falling faster than the step can follow, so the step doubles. A change of bit means the estimate is hovering around the signal, so the step halves. The step never leaves a fixed window set by two parameters.

The decoder uses the same adaptation order, clamp limits, saturation and reset state as the matching encoder's feedback loop. Given the encoder's bit stream, it therefore produces the same estimate sequence as the encoder. Bits arrive with a valid strobe, at most one per clock. Each accepted bit yields one output sample, marked by its own strobe one cycle later. Output smoothing, analog reconstruction and bit-error recovery lie outside this block.

Top module: `adm_decoder`

## Requirements
- R1: After reset the output sample is 0 and the output strobe is low. The step equals `STEP_MIN` and the remembered previous bit is 0. So a first bit of 1 gives a sample of +`STEP_MIN`, and a first bit of 0 gives −2·`STEP_MIN` (clamped to `STEP_MAX`).
- R2: An accepted bit of 1 adds the adapted step to the estimate, and an accepted bit of 0 subtracts it.
- R3: When the accepted bit equals the previous accepted bit, the step doubles, limited to `STEP_MAX`.
- R4: When the accepted bit differs from the previous accepted bit, the step halves (integer division), limited below by `STEP_MIN`.
- R5: The step is adapted first, and the adapted value is the one added to or subtracted from the estimate in the same bit.
- R6: The estimate saturates at +(2^(OUT_W−1)−1) and −2^(OUT_W−1) instead of wrapping.
- R7: `out_vld` is high in the cycle after each cycle with `bit_vld` high, and low otherwise. Without an accepted bit, the sample, step and previous bit keep their values.
- R8: Bits presented on consecutive clocks are each accepted, with no idle cycle needed between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bit_vld | input | 1 | Strobe: `bit_in` is to be accepted this cycle |
| bit_in | input | 1 | Received delta bit: 1 = up, 0 = down |
| out_vld | output | 1 | Strobe: `sample` holds the estimate for the last accepted bit |
| sample | output | OUT_W | Reconstructed signed estimate, two's complement |

## Verification
Step clamping and estimate saturation can act on the same bit. That happens when a long run of equal bits has pinned the step at its maximum and the same bit also drives the estimate into a rail. It also happens on the first reversal away from a rail, where the step halves while the estimate leaves saturation. The bench provokes both cases with long runs of ones and then of zeros in a small configuration. It also sweeps every 10-bit pattern from reset. Every sample is compared against an arithmetic model that applies the step rule first and then the saturating add.

// File: rtl/adm_pkg.sv
package adm_pkg;
  // Step update selected by the relation of the current bit to the previous one.
  typedef enum logic [1:0] {
    STEP_GROW   = 2'd0,
    STEP_SHRINK = 2'd1
  } step_act_e;

  // Direction encoded by the received bit.
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;
endpackage

// File: rtl/adm_step_adapt.sv
// Next step size from the bit history: doubles on repeat, halves on change, clamped.
module adm_step_adapt
  import adm_pkg::*;
#(
  parameter int STEP_W   = 11,
  parameter int STEP_MIN = 1,
  parameter int STEP_MAX = 1024
) (
  input  logic [STEP_W-1:0] step_q,
  input  logic              bit_in,
  input  logic              prev_bit,
  output logic [STEP_W-1:0] step_nx
);
  localparam logic [STEP_W:0]   MAX_X = (STEP_W+1)'(STEP_MAX);
  localparam logic [STEP_W-1:0] MIN_S = STEP_W'(STEP_MIN);
  localparam logic [STEP_W-1:0] MAX_S = STEP_W'(STEP_MAX);

  step_act_e act;
  assign act = (bit_in == prev_bit) ? STEP_GROW : STEP_SHRINK;

  generate
    if (STEP_MIN == STEP_MAX) begin : g_fixed
      assign step_nx = MIN_S;
    end else begin : g_adapt
      logic [STEP_W:0]   dbl;
      logic [STEP_W-1:0] half;
      assign dbl  = {step_q, 1'b0};
      assign half = step_q >> 1;

      always_comb begin
        step_nx = step_q;
        case (act)
          STEP_GROW:   step_nx = (dbl > MAX_X) ? MAX_S : dbl[STEP_W-1:0];
          STEP_SHRINK: step_nx = (half < MIN_S) ? MIN_S : half;
          default:     step_nx = step_q;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/adm_accum.sv
// Saturating signed add or subtract of the step into the estimate.
module adm_accum
  import adm_pkg::*;
#(
  parameter int OUT_W  = 16,
  parameter int STEP_W = 11
) (
  input  logic [OUT_W-1:0]  est_q,
  input  logic [STEP_W-1:0] step,
  input  logic              bit_in,
  output logic [OUT_W-1:0]  est_nx
);
  localparam int            PAD      = OUT_W + 1 - STEP_W;
  localparam logic [OUT_W-1:0] POS_RAIL = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] NEG_RAIL = {1'b1, {(OUT_W-1){1'b0}}};

  logic [OUT_W:0] ext_est;
  logic [OUT_W:0] delta;
  logic [OUT_W:0] sum;
  dir_e           dir;

  assign dir     = dir_e'(bit_in);
  assign ext_est = {est_q[OUT_W-1], est_q};
  assign delta   = {{PAD{1'b0}}, step};

  always_comb begin
    if (dir == DIR_UP) sum = ext_est + delta;
    else               sum = ext_est - delta;

    if (sum[OUT_W] != sum[OUT_W-1]) est_nx = sum[OUT_W] ? NEG_RAIL : POS_RAIL;
    else                            est_nx = sum[OUT_W-1:0];
  end
endmodule

// File: rtl/adm_decoder.sv
// Adaptive delta stream decoder: one bit in, one saturated signed sample out.
module adm_decoder #(
  parameter int OUT_W    = 16,
  parameter int STEP_MIN = 1,
  parameter int STEP_MAX = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_vld,
  input  logic             bit_in,
  output logic             out_vld,
  output logic [OUT_W-1:0] sample
);
  localparam int STEP_W = $clog2(STEP_MAX + 1);
  localparam logic [STEP_W-1:0] STEP_RST = STEP_W'(STEP_MIN);

  logic [OUT_W-1:0]  est_q,  est_d,  est_nx;
  logic [STEP_W-1:0] step_q, step_d, step_nx;
  logic              prev_q, prev_d;
  logic              vld_q,  vld_d;

  adm_step_adapt #(
    .STEP_W  (STEP_W),
    .STEP_MIN(STEP_MIN),
    .STEP_MAX(STEP_MAX)
  ) u_step (
    .step_q  (step_q),
    .bit_in  (bit_in),
    .prev_bit(prev_q),
    .step_nx (step_nx)
  );

  adm_accum #(
    .OUT_W (OUT_W),
    .STEP_W(STEP_W)
  ) u_acc (
    .est_q (est_q),
    .step  (step_nx),
    .bit_in(bit_in),
    .est_nx(est_nx)
  );

  // Next state: advance only on an accepted bit.
  always_comb begin
    est_d  = est_q;
    step_d = step_q;
    prev_d = prev_q;
    vld_d  = bit_vld;
    if (bit_vld) begin
      est_d  = est_nx;
      step_d = step_nx;
      prev_d = bit_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      est_q  <= '0;
      step_q <= STEP_RST;
      prev_q <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      est_q  <= est_d;
      step_q <= step_d;
      prev_q <= prev_d;
      vld_q  <= vld_d;
    end
  end

  assign sample  = est_q;
  assign out_vld = vld_q;
endmodule

// File: rtl/adm_decoder_chk.sv
module adm_decoder_chk #(
  parameter int OUT_W    = 16,
  parameter int STEP_MIN = 1,
  parameter int STEP_MAX = 1024,
  parameter int STEP_W   = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bit_vld,
  input logic              bit_in,
  input logic              out_vld,
  input logic [OUT_W-1:0]  sample,
  input logic [STEP_W-1:0] step_q,
  input logic              prev_q
);
  localparam logic signed [OUT_W-1:0] POS_RAIL = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic signed [OUT_W-1:0] NEG_RAIL = {1'b1, {(OUT_W-1){1'b0}}};

  a_r7_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld |=> out_vld);
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |=> !out_vld);
  a_r7_hold_sample: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |=> $stable(sample) && $stable(step_q) && $stable(prev_q));
  a_r2_up: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld && bit_in && $signed(sample) != POS_RAIL) |=>
      $signed(sample) > $signed($past(sample)));
  a_r2_down: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld && !bit_in && $signed(sample) != NEG_RAIL) |=>
      $signed(sample) < $signed($past(sample)));
  a_r3_grow: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld && bit_in == prev_q && int'(step_q) < STEP_MAX) |=>
      step_q > $past(step_q));
  a_r4_shrink: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld && bit_in != prev_q && int'(step_q) > STEP_MIN) |=>
      step_q < $past(step_q));
  a_r4_step_window: assert property (@(posedge clk) disable iff (!rst_n)
    int'(step_q) >= STEP_MIN && int'(step_q) <= STEP_MAX);
  a_r8_bit_taken: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld |=> prev_q == $past(bit_in));
endmodule

bind adm_decoder adm_decoder_chk #(
  .OUT_W   (OUT_W),
  .STEP_MIN(STEP_MIN),
  .STEP_MAX(STEP_MAX),
  .STEP_W  (STEP_W)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .bit_vld(bit_vld),
  .bit_in (bit_in),
  .out_vld(out_vld),
  .sample (sample),
  .step_q (step_q),
  .prev_q (prev_q)
);

// File: tb/sim_adm_decoder.sv
`timescale 1ns/1ps
module sim_adm_decoder;
  localparam int W    = 8;
  localparam int SMIN = 1;
  localparam int SMAX = 16;
  localparam int PMAX = (1 << (W-1)) - 1;
  localparam int NMIN = -(1 << (W-1));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_vld = 1'b0;
  logic bit_in = 1'b0;
  logic out_vld;
  logic [W-1:0] sample;

  int n_chk = 0;
  int n_fail = 0;
  int m_est, m_step, m_prev;

  always #2 clk = ~clk;

  adm_decoder #(.OUT_W(W), .STEP_MIN(SMIN), .STEP_MAX(SMAX)) u0 (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
    .out_vld(out_vld), .sample(sample)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    bit_vld = 1'b0;
    @(negedge clk);
    check("R1 sample after reset", $signed(sample), 0);
    check("R1 out_vld after reset", int'(out_vld), 0);
    rst_n = 1'b1;
    m_est = 0; m_step = SMIN; m_prev = 0;
  endtask

  // R3 R4 R5 R6 model: adapt the step first, then saturating update.
  task automatic send(input logic b);
    if (int'(b) == m_prev) m_step = (m_step * 2 > SMAX) ? SMAX : m_step * 2;
    else                   m_step = (m_step / 2 < SMIN) ? SMIN : m_step / 2;
    m_est = b ? m_est + m_step : m_est - m_step;
    if (m_est > PMAX) m_est = PMAX;
    if (m_est < NMIN) m_est = NMIN;
    m_prev = int'(b);
    bit_vld = 1'b1;
    bit_in = b;
    @(negedge clk);
    check("R2 R5 R8 sample", $signed(sample), m_est);
    check("R7 out_vld after bit", int'(out_vld), 1);
  endtask

  task automatic idle();
    bit_vld = 1'b0;
    bit_in = ~bit_in;
    @(negedge clk);
    check("R7 out_vld idle", int'(out_vld), 0);
    check("R7 sample held", $signed(sample), m_est);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1 first-bit cases.
    do_reset();
    send(1'b1);
    check("R1 first one gives +min", $signed(sample), SMIN);
    do_reset();
    send(1'b0);
    check("R1 first zero gives -2min", $signed(sample), -2 * SMIN);

    // Sweep of all 10-bit patterns from reset, some with an idle gap (R7, R8).
    for (int p = 0; p < 1024; p++) begin
      do_reset();
      for (int i = 0; i < 10; i++) begin
        send(p[i]);
        if (p[0] && i == 4) idle();
      end
      idle();
    end

    // R6 with R3 clamp: long rise into the positive rail, then fall to the negative rail.
    do_reset();
    for (int i = 0; i < 20; i++) send(1'b1);
    check("R6 positive rail", $signed(sample), PMAX);
    for (int i = 0; i < 30; i++) send(1'b0);
    check("R6 negative rail", $signed(sample), NMIN);
    // R4 reversal away from the rail with step at max: halves to SMAX/2.
    send(1'b1);
    check("R4 reversal off rail", $signed(sample), NMIN + SMAX / 2);
    // Alternating bits drive the step down to the floor (R4).
    for (int i = 0; i < 12; i++) send(i[0]);
    idle();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule